// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address. It reads two 32-bit entries from memory: first the directory entry, then the table entry. A caller raises a request with the virtual address, the access type (read or write) and the current privilege level. The walker then issues its reads one at a time on a simple request/response memory port. When the walk ends it returns either the physical address or a page fault with a three-bit fault code. The physical frame of the directory is held in a root register. A separate write port loads that register, and the load takes effect only while the walker is idle.

Every entry keeps its physical frame number in bits 31:12 and its attribute flags in bits 11:0. The walker checks three flags: present (bit 0), writable (bit 1) and user-accessible (bit 2). It checks them on the directory entry and again on the table entry. If the directory entry is not present, the walk stops after a single read. Privilege level 3 counts as user mode and levels 0 to 2 count as supervisor mode. Supervisor accesses ignore the user-accessible and writable flags.

The controller has six named states:
- `WALK_IDLE`: ready for a request. It moves to `WALK_DIR_ISSUE` when a request arrives.
- `WALK_DIR_ISSUE`: drives the directory read for one cycle, then moves to `WALK_DIR_WAIT`.
- `WALK_DIR_WAIT`: waits for the response. It goes to `WALK_REPORT` if the entry faults, otherwise to `WALK_TBL_ISSUE`.
- `WALK_TBL_ISSUE`: drives the table read for one cycle, then moves to `WALK_TBL_WAIT`.
- `WALK_TBL_WAIT`: waits for the response, then moves to `WALK_REPORT`.
- `WALK_REPORT`: presents the result for one cycle, then returns to `WALK_IDLE`.

Top module: `pgw_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `rsp_valid` and `mem_rd_req` are 0.
- R2: The first read goes to {root frame, vaddr[31:22], 2'b00}. The root frame is bits 31:12 of the last accepted root load, and bits 11:0 of the loaded value are ignored.
- R3: The second read goes to {directory entry[31:12], vaddr[21:12], 2'b00}.
- R4: A walk with no fault returns `rsp_paddr` = {table entry[31:12], vaddr[11:0]}, with `rsp_fault` = 0 and `rsp_fault_code` = 0.
- R5: A directory entry with bit 0 clear ends the walk with a fault after exactly one memory read. In that case `rsp_paddr` is 0.
- R6: A table entry with bit 0 clear ends the walk with a not-present fault after two reads.
- R7: A user access (`req_cpl` = 3) faults if bit 2 of either entry is clear. A supervisor access (`req_cpl` 0 to 2) is not checked against bit 2.
- R8: A user write faults if bit 1 of either entry is clear. A supervisor write is allowed whatever bit 1 holds.
- R9: The fault code bits are defined as follows:
  - bit 0 is 1 for a protection fault and 0 for a not-present fault;
  - bit 1 is 1 for a write;
  - bit 2 is 1 for a user-mode access.
- R10: The walker accepts a request only in the idle state, and `req_ready` is 0 at all other times. A request held while the walker is busy is ignored. Each accepted request produces exactly one `rsp_valid` pulse, one cycle wide.
- R11: A root load raised while a walk is in progress has no effect on the root frame.
- R12: `mem_rd_req` is a one-cycle pulse. No new read is issued while a read is still waiting for its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| root_wr_en | input | 1 | Load the root register (honoured only when idle) |
| root_wr_data | input | 32 | Root value; bits 31:12 give the directory frame |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_cpl | input | 2 | Current privilege level, 3 = user |
| req_ready | output | 1 | Walker idle and able to accept a request |
| mem_rd_req | output | 1 | One-cycle memory read request |
| mem_rd_addr | output | 32 | Physical address of the entry being read |
| mem_rsp_valid | input | 1 | Read data is valid |
| mem_rsp_data | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_fault | output | 1 | The walk ended in a page fault |
| rsp_fault_code | output | 3 | Fault code, encoded as in R9 |
| rsp_paddr | output | 32 | Physical address; 0 on a fault |

## Verification
The assertions watch every cycle for the following properties:
- the result pulse is one cycle wide;
- a memory read pulse is one cycle wide;
- `req_ready` drops after a request is accepted;
- a non-present directory entry is never followed by a table read;
- a successful result keeps the request's page offset and carries a zero code;
- the root frame holds steady under loads raised during a walk.

The bench scenarios cover the behaviour that depends on memory contents and must be compared against independently computed values:
- the exact read addresses and physical addresses;
- each fault code for the combinations of flag, level, privilege and access type;
- requests ignored while the walker is busy;
- the root frame in force after loads raised while busy and while idle.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    localparam int unsigned VA_W        = 32;
    localparam int unsigned PA_W        = 32;
    localparam int unsigned OFFS_W      = 12;
    localparam int unsigned IDX_W       = 10;
    localparam int unsigned ENTRY_SHIFT = 2;
    localparam int unsigned CPL_W       = 2;
    localparam int unsigned CODE_W      = 3;

    localparam int unsigned FRAME_W     = PA_W - OFFS_W;
    localparam int unsigned DIR_LSB     = OFFS_W + IDX_W;

    // attribute flag positions inside an entry
    localparam int unsigned FLAG_PRESENT = 0;
    localparam int unsigned FLAG_WRITE   = 1;
    localparam int unsigned FLAG_USER    = 2;

    // fault code bit positions
    localparam int unsigned CODE_PROT   = 0;
    localparam int unsigned CODE_WRITE  = 1;
    localparam int unsigned CODE_USER   = 2;

    localparam logic [CPL_W-1:0] USER_CPL = 2'd3;

    typedef enum logic [2:0] {
        WALK_IDLE,
        WALK_DIR_ISSUE,
        WALK_DIR_WAIT,
        WALK_TBL_ISSUE,
        WALK_TBL_WAIT,
        WALK_REPORT
    } walk_state_e;

    typedef struct packed {
        logic is_write;
        logic is_user;
    } access_t;

endpackage

// File: rtl/pgw_root_reg.sv
module pgw_root_reg
    import pgw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_en,
    input  logic [PA_W-1:0]    load_data,
    input  logic               busy,
    output logic [FRAME_W-1:0] root_frame
);

    logic [FRAME_W-1:0] frame_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else if (load_en && !busy) begin
            frame_q <= load_data[PA_W-1:OFFS_W];
        end
    end

    assign root_frame = frame_q;

    // R11
    root_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && busy) |=> $stable(frame_q));

endmodule

// File: rtl/pgw_entry_check.sv
module pgw_entry_check
    import pgw_pkg::*;
(
    input  logic [OFFS_W-1:0] flags,
    input  access_t           acc,
    output logic              not_present,
    output logic              prot_fault
);

    logic user_denied;
    logic write_denied;

    always_comb begin
        not_present  = !flags[FLAG_PRESENT];
        user_denied  = acc.is_user && !flags[FLAG_USER];
        write_denied = acc.is_user && acc.is_write && !flags[FLAG_WRITE];
        prot_fault   = !not_present && (user_denied || write_denied);
    end

endmodule

// File: rtl/pgw_addr_sel.sv
module pgw_addr_sel
    import pgw_pkg::*;
(
    input  logic               sel_table,
    input  logic [FRAME_W-1:0] root_frame,
    input  logic [FRAME_W-1:0] dir_frame,
    input  logic [IDX_W-1:0]   dir_idx,
    input  logic [IDX_W-1:0]   tbl_idx,
    output logic [PA_W-1:0]    rd_addr
);

    always_comb begin
        if (sel_table) begin
            rd_addr = {dir_frame, tbl_idx, {ENTRY_SHIFT{1'b0}}};
        end else begin
            rd_addr = {root_frame, dir_idx, {ENTRY_SHIFT{1'b0}}};
        end
    end

endmodule

// File: rtl/pgw_walker.sv
module pgw_walker
    import pgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              root_wr_en,
    input  logic [PA_W-1:0]   root_wr_data,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    input  logic [CPL_W-1:0]  req_cpl,
    output logic              req_ready,
    output logic              mem_rd_req,
    output logic [PA_W-1:0]   mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [PA_W-1:0]   mem_rsp_data,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [CODE_W-1:0] rsp_fault_code,
    output logic [PA_W-1:0]   rsp_paddr
);

    walk_state_e        state_q, state_d;
    logic [VA_W-1:0]    vaddr_q;
    access_t            acc_q;
    logic [FRAME_W-1:0] dir_frame_q;
    logic [FRAME_W-1:0] root_frame;
    logic               res_fault_q;
    logic [CODE_W-1:0]  res_code_q;
    logic [PA_W-1:0]    res_paddr_q;

    logic               accept;
    logic               busy;
    logic               ent_not_present;
    logic               ent_prot;
    logic               ent_fault;
    logic [CODE_W-1:0]  fault_code;

    assign accept    = (state_q == WALK_IDLE) && req_valid;
    assign busy      = (state_q != WALK_IDLE);
    assign ent_fault = ent_not_present || ent_prot;

    pgw_root_reg u_root (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (root_wr_en),
        .load_data  (root_wr_data),
        .busy       (busy),
        .root_frame (root_frame)
    );

    pgw_entry_check u_check (
        .flags       (mem_rsp_data[OFFS_W-1:0]),
        .acc         (acc_q),
        .not_present (ent_not_present),
        .prot_fault  (ent_prot)
    );

    pgw_addr_sel u_addr (
        .sel_table  (state_q == WALK_TBL_ISSUE),
        .root_frame (root_frame),
        .dir_frame  (dir_frame_q),
        .dir_idx    (vaddr_q[VA_W-1:DIR_LSB]),
        .tbl_idx    (vaddr_q[DIR_LSB-1:OFFS_W]),
        .rd_addr    (mem_rd_addr)
    );

    always_comb begin
        fault_code             = '0;
        fault_code[CODE_PROT]  = !ent_not_present;
        fault_code[CODE_WRITE] = acc_q.is_write;
        fault_code[CODE_USER]  = acc_q.is_user;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WALK_IDLE:      if (req_valid) state_d = WALK_DIR_ISSUE;
            WALK_DIR_ISSUE: state_d = WALK_DIR_WAIT;
            WALK_DIR_WAIT: begin
                if (mem_rsp_valid) begin
                    state_d = ent_fault ? WALK_REPORT : WALK_TBL_ISSUE;
                end
            end
            WALK_TBL_ISSUE: state_d = WALK_TBL_WAIT;
            WALK_TBL_WAIT:  if (mem_rsp_valid) state_d = WALK_REPORT;
            WALK_REPORT:    state_d = WALK_IDLE;
            default:        state_d = WALK_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WALK_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // walk context and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vaddr_q     <= '0;
            acc_q       <= '0;
            dir_frame_q <= '0;
            res_fault_q <= 1'b0;
            res_code_q  <= '0;
            res_paddr_q <= '0;
        end else if (accept) begin
            vaddr_q        <= req_vaddr;
            acc_q.is_write <= req_write;
            acc_q.is_user  <= (req_cpl == USER_CPL);
            res_fault_q    <= 1'b0;
            res_code_q     <= '0;
            res_paddr_q    <= '0;
        end else if (mem_rsp_valid && (state_q == WALK_DIR_WAIT)) begin
            dir_frame_q <= mem_rsp_data[PA_W-1:OFFS_W];
            if (ent_fault) begin
                res_fault_q <= 1'b1;
                res_code_q  <= fault_code;
            end
        end else if (mem_rsp_valid && (state_q == WALK_TBL_WAIT)) begin
            if (ent_fault) begin
                res_fault_q <= 1'b1;
                res_code_q  <= fault_code;
            end else begin
                res_paddr_q <= {mem_rsp_data[PA_W-1:OFFS_W], vaddr_q[OFFS_W-1:0]};
            end
        end
    end

    // outputs
    always_comb begin
        req_ready      = (state_q == WALK_IDLE);
        mem_rd_req     = (state_q == WALK_DIR_ISSUE) || (state_q == WALK_TBL_ISSUE);
        rsp_valid      = (state_q == WALK_REPORT);
        rsp_fault      = res_fault_q;
        rsp_fault_code = res_code_q;
        rsp_paddr      = res_paddr_q;
    end

    // R10
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R10
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> !req_ready);

    // R12
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req);

    // R5
    dir_absent_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == WALK_DIR_WAIT) && mem_rsp_valid && !mem_rsp_data[FLAG_PRESENT])
        |=> (rsp_valid && !mem_rd_req));

    // R4
    offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |->
        ((rsp_paddr[OFFS_W-1:0] == vaddr_q[OFFS_W-1:0]) && (rsp_fault_code == '0)));

endmodule

// File: tb/pgw_walker_tb_top.sv
module pgw_walker_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        root_wr_en = 1'b0;
    logic [31:0] root_wr_data = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_cpl = '0;
    logic        req_ready;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [2:0]  rsp_fault_code;
    logic [31:0] rsp_paddr;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    pgw_walker dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .root_wr_en     (root_wr_en),
        .root_wr_data   (root_wr_data),
        .req_valid      (req_valid),
        .req_vaddr      (req_vaddr),
        .req_write      (req_write),
        .req_cpl        (req_cpl),
        .req_ready      (req_ready),
        .mem_rd_req     (mem_rd_req),
        .mem_rd_addr    (mem_rd_addr),
        .mem_rsp_valid  (mem_rsp_valid),
        .mem_rsp_data   (mem_rsp_data),
        .rsp_valid      (rsp_valid),
        .rsp_fault      (rsp_fault),
        .rsp_fault_code (rsp_fault_code),
        .rsp_paddr      (rsp_paddr)
    );

    // memory model
    logic [31:0] m_addr [16];
    logic [31:0] m_data [16];
    int          m_n = 0;
    int          rsp_lat = 1;
    int          rd_cnt = 0;
    int          overlap_err = 0;
    logic [31:0] rd_log [2];
    logic [31:0] root_now = '0;

    function automatic logic [31:0] lookup(input logic [31:0] a);
        logic [31:0] d;
        d = '0;
        for (int i = 0; i < 16; i++) begin
            if (i < m_n && m_addr[i] == a) d = m_data[i];
        end
        return d;
    endfunction

    task automatic map_entry(input logic [31:0] a, input logic [31:0] d);
        m_addr[m_n] = a;
        m_data[m_n] = d;
        m_n++;
    endtask

    initial begin : responder
        logic        pend;
        int          cnt;
        logic [31:0] pa;
        pend = 1'b0;
        cnt  = 0;
        pa   = '0;
        forever begin
            @(negedge clk);
            if (mem_rsp_valid) mem_rsp_valid = 1'b0;
            if (pend) begin
                if (cnt <= 1) begin
                    mem_rsp_data  = lookup(pa);
                    mem_rsp_valid = 1'b1;
                    pend          = 1'b0;
                end else begin
                    cnt--;
                end
            end
            if (mem_rd_req) begin
                if (pend) overlap_err++;
                pend = 1'b1;
                cnt  = rsp_lat;
                pa   = mem_rd_addr;
                if (rd_cnt < 2) rd_log[rd_cnt] = mem_rd_addr;
                rd_cnt++;
            end
        end
    end

    // expected-value helpers from the requirements
    function automatic logic [31:0] exp_dir_addr(input logic [31:0] root, input logic [31:0] va);
        return {root[31:12], va[31:22], 2'b00};
    endfunction

    function automatic logic [31:0] exp_tbl_addr(input logic [31:0] ent, input logic [31:0] va);
        return {ent[31:12], va[21:12], 2'b00};
    endfunction

    function automatic logic [31:0] exp_phys(input logic [31:0] ent, input logic [31:0] va);
        return {ent[31:12], va[11:0]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load_root(input logic [31:0] v);
        @(negedge clk);
        root_wr_en   = 1'b1;
        root_wr_data = v;
        @(negedge clk);
        root_wr_en   = 1'b0;
    endtask

    task automatic start_walk(input logic [31:0] va, input logic wr, input logic [1:0] cpl);
        @(negedge clk);
        rd_cnt    = 0;
        req_valid = 1'b1;
        req_vaddr = va;
        req_write = wr;
        req_cpl   = cpl;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_rsp(output logic f, output logic [2:0] c, output logic [31:0] p);
        f = 1'b0;
        c = '0;
        p = '0;
        for (int i = 0; i < 60; i++) begin
            if (rsp_valid) begin
                f = rsp_fault;
                c = rsp_fault_code;
                p = rsp_paddr;
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        check(!rsp_valid, "R10 pulse width", 32'(rsp_valid), 32'd0);
    endtask

    task automatic walk_and_check(input string req, input logic [31:0] va, input logic wr,
                                  input logic [1:0] cpl, input logic exp_f, input logic [2:0] exp_c,
                                  input logic [31:0] exp_p, input int exp_reads,
                                  input logic [31:0] exp_tbl);
        logic        f;
        logic [2:0]  c;
        logic [31:0] p;
        start_walk(va, wr, cpl);
        wait_rsp(f, c, p);
        check(f == exp_f, {req, " fault"}, 32'(f), 32'(exp_f));
        check(c == exp_c, {req, " code"}, 32'(c), 32'(exp_c));
        check(p == exp_p, {req, " paddr"}, p, exp_p);
        check(rd_cnt == exp_reads, {req, " read count"}, 32'(rd_cnt), 32'(exp_reads));
        check(rd_log[0] == exp_dir_addr(root_now, va), "R2 directory read address",
              rd_log[0], exp_dir_addr(root_now, va));
        if (exp_reads == 2) begin
            check(rd_log[1] == exp_tbl, "R3 table read address", rd_log[1], exp_tbl);
        end
    endtask

    task automatic t_reset();
        check(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
        check(rsp_valid == 1'b0, "R1 no result after reset", 32'(rsp_valid), 32'd0);
        check(mem_rd_req == 1'b0, "R1 no read after reset", 32'(mem_rd_req), 32'd0);
    endtask

    task automatic t_translate();
        load_root(32'h0010_0ABC);
        root_now = 32'h0010_0ABC;
        rsp_lat = 1;
        walk_and_check("R4 user read", 32'h0040_3123, 1'b0, 2'd3, 1'b0, 3'b000,
                       exp_phys(32'h1234_5007, 32'h0040_3123), 2,
                       exp_tbl_addr(32'h0020_0007, 32'h0040_3123));
        rsp_lat = 3;
        walk_and_check("R4 supervisor write slow memory", 32'h0040_3FFF, 1'b1, 2'd0, 1'b0, 3'b000,
                       exp_phys(32'h1234_5007, 32'h0040_3FFF), 2,
                       exp_tbl_addr(32'h0020_0007, 32'h0040_3FFF));
        rsp_lat = 1;
    endtask

    task automatic t_dir_absent();
        walk_and_check("R5 directory not present", 32'h0080_0000, 1'b1, 2'd0, 1'b1, 3'b010,
                       32'h0, 1, 32'h0);
    endtask

    task automatic t_tbl_absent();
        walk_and_check("R6 table not present", 32'h0040_4000, 1'b0, 2'd3, 1'b1, 3'b100,
                       32'h0, 2, exp_tbl_addr(32'h0020_0007, 32'h0040_4000));
    endtask

    task automatic t_owner();
        walk_and_check("R7 user on supervisor directory", 32'h00C0_5000, 1'b0, 2'd3, 1'b1, 3'b101,
                       32'h0, 1, 32'h0);
        walk_and_check("R7 supervisor on supervisor directory", 32'h00C0_5000, 1'b0, 2'd0, 1'b0,
                       3'b000, exp_phys(32'h00AA_A007, 32'h00C0_5000), 2,
                       exp_tbl_addr(32'h0030_0003, 32'h00C0_5000));
        walk_and_check("R7 user on supervisor table", 32'h0040_6010, 1'b0, 2'd3, 1'b1, 3'b101,
                       32'h0, 2, exp_tbl_addr(32'h0020_0007, 32'h0040_6010));
        walk_and_check("R9 level 2 is supervisor", 32'h0040_6010, 1'b0, 2'd2, 1'b0, 3'b000,
                       exp_phys(32'h00BB_B003, 32'h0040_6010), 2,
                       exp_tbl_addr(32'h0020_0007, 32'h0040_6010));
    endtask

    task automatic t_write_prot();
        walk_and_check("R8 user write read-only table", 32'h0040_7ABC, 1'b1, 2'd3, 1'b1, 3'b111,
                       32'h0, 2, exp_tbl_addr(32'h0020_0007, 32'h0040_7ABC));
        walk_and_check("R8 supervisor write read-only table", 32'h0040_7ABC, 1'b1, 2'd0, 1'b0,
                       3'b000, exp_phys(32'h00CC_C005, 32'h0040_7ABC), 2,
                       exp_tbl_addr(32'h0020_0007, 32'h0040_7ABC));
        walk_and_check("R8 user write read-only directory", 32'h0100_0456, 1'b1, 2'd3, 1'b1, 3'b111,
                       32'h0, 1, 32'h0);
        walk_and_check("R8 user read read-only directory", 32'h0100_0456, 1'b0, 2'd3, 1'b0, 3'b000,
                       exp_phys(32'h00DD_D007, 32'h0100_0456), 2,
                       exp_tbl_addr(32'h0040_0005, 32'h0100_0456));
        walk_and_check("R8 level 1 write read-only directory", 32'h0100_0456, 1'b1, 2'd1, 1'b0,
                       3'b000, exp_phys(32'h00DD_D007, 32'h0100_0456), 2,
                       exp_tbl_addr(32'h0040_0005, 32'h0100_0456));
    endtask

    task automatic t_busy_ignore();
        bit          ready_seen;
        logic [31:0] p;
        ready_seen = 1'b0;
        p = '0;
        start_walk(32'h0040_3123, 1'b0, 2'd3);
        req_valid = 1'b1;
        req_vaddr = 32'h00C0_5000;
        for (int i = 0; i < 60; i++) begin
            if (rsp_valid) begin
                p = rsp_paddr;
                break;
            end
            if (req_ready) ready_seen = 1'b1;
            @(negedge clk);
        end
        req_valid = 1'b0;
        check(!ready_seen, "R10 not ready while busy", 32'(ready_seen), 32'd0);
        check(p == exp_phys(32'h1234_5007, 32'h0040_3123), "R10 busy request ignored", p,
              exp_phys(32'h1234_5007, 32'h0040_3123));
        @(negedge clk);
        check(!rsp_valid, "R10 single result", 32'(rsp_valid), 32'd0);
        @(negedge clk);
        check(req_ready && rd_cnt == 2, "R10 no second walk", 32'(rd_cnt), 32'd2);
    endtask

    task automatic t_root_busy();
        logic        f;
        logic [2:0]  c;
        logic [31:0] p;
        start_walk(32'h0040_3123, 1'b0, 2'd3);
        load_root(32'h0090_0000);
        wait_rsp(f, c, p);
        walk_and_check("R11 root load while busy ignored", 32'h0040_3123, 1'b0, 2'd3, 1'b0, 3'b000,
                       exp_phys(32'h1234_5007, 32'h0040_3123), 2,
                       exp_tbl_addr(32'h0020_0007, 32'h0040_3123));
        load_root(32'h0050_0FFF);
        root_now = 32'h0050_0FFF;
        walk_and_check("R2 root load while idle", 32'h0000_0000, 1'b0, 2'd3, 1'b1, 3'b100,
                       32'h0, 1, 32'h0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        map_entry(32'h0010_0004, 32'h0020_0007);
        map_entry(32'h0020_000C, 32'h1234_5007);
        map_entry(32'h0010_000C, 32'h0030_0003);
        map_entry(32'h0030_0014, 32'h00AA_A007);
        map_entry(32'h0020_0018, 32'h00BB_B003);
        map_entry(32'h0020_001C, 32'h00CC_C005);
        map_entry(32'h0010_0010, 32'h0040_0005);
        map_entry(32'h0040_0000, 32'h00DD_D007);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_translate();
        t_dir_absent();
        t_tbl_absent();
        t_owner();
        t_write_prot();
        t_busy_ignore();
        t_root_busy();
        check(overlap_err == 0, "R12 one read outstanding", 32'(overlap_err), 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule